// File: doc/BRIEF.md
# Ternary Fully Connected Layer

This block computes one fully connected neural-network layer in which every weight and every input activation takes one of three values: -1, 0 or +1. A parameterised number of neurons run side by side. Each neuron owns a small run-time writable weight store and a signed accumulator. For every incoming activation the neuron adds one, subtracts one or holds, so there is no multiplier anywhere in the datapath. The input vector arrives serially at one activation per clock. The first activation is marked with a start flag, and the vector ends by count after a fixed number of inputs.

When the last input of a vector has been summed, every neuron's total is captured into a shift buffer. The totals then leave the block one neuron per cycle, tagged with the neuron number and a last marker, and go to a downstream thresholding stage. The accumulators are free again as soon as the capture is done. The next vector can therefore be fed with no gap while the previous results are still draining. The weights may only be rewritten while the layer holds no work in flight, and an `idle` output shows when that is the case.

Top module: `tern_fc_layer`

## Requirements
- R1: Ternary codes are two-bit two's complement: 2'b01 is +1, 2'b11 is -1 and 2'b00 is 0. The unused code 2'b10 counts as 0, whether it is a weight or an activation.
- R2: For each neuron k, `out_sum` is the exact signed sum over all inputs i of weight(k,i) times activation(i). It is a two's-complement value of $clog2(N_IN+1)+1 bits, so the extremes +N_IN and -N_IN are reported without wrap.
- R3: An input whose activation or weight is zero does not change that neuron's sum, so an all-zero vector yields 0 for every neuron.
- R4: One activation is taken on each clock where `in_valid` is high within an open vector. Cycles with `in_valid` low inside a vector are pauses and do not change any result.
- R5: An accepted input with `in_sof` high opens a new vector and restarts every sum from that input alone. This holds even when the previous vector is unfinished, or its last input was on the clock just before.
- R6: A vector closes after N_IN accepted inputs. Neuron k's sum is presented with `out_valid` high on the clock edge 2+k cycles after the edge that took the last input. `out_idx` equals k at that point, and `out_last` is high only for k = N_NEUR-1.
- R7: While no vector is open, an input with `in_valid` high and `in_sof` low is ignored: no output follows and `idle` stays high.
- R8: A write with `wr_en` high while `idle` is high stores `wr_data` as the weight of neuron `wr_neuron` for input `wr_index`. Every vector that starts afterwards uses it.
- R9: A write is dropped when `idle` is low, or when it falls in the same cycle as an accepted `in_sof`. `idle` is high only when no vector is open, no input is still being summed and no result is still draining.
- R10: Summing of the next vector overlaps the drain of the previous one. With N_IN equal to N_NEUR, back-to-back vectors give an unbroken run of `out_valid` beats.
- R11: After reset `out_valid` is low and `idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Activation present this cycle |
| in_sof | input | 1 | Activation is the first of a vector |
| in_act | input | 2 | Ternary activation code |
| wr_en | input | 1 | Weight write request |
| wr_neuron | input | $clog2(N_NEUR) | Neuron whose weight is written |
| wr_index | input | $clog2(N_IN) | Input position of the weight written |
| wr_data | input | 2 | Ternary weight code |
| idle | output | 1 | No work in flight; weight writes accepted |
| out_valid | output | 1 | Result beat present |
| out_idx | output | $clog2(N_NEUR) | Neuron number of the beat |
| out_sum | output | $clog2(N_IN+1)+1 | Signed neuron sum |
| out_last | output | 1 | Beat belongs to the final neuron |

## Verification
Two of the block's functions can land on the same edge. The first is a weight write against the opening input of a vector: the bench raises `wr_en` on the very clock that carries an accepted `in_sof`, and judges the outcome by whether the following vector's sums still match the old weights. The second is the last drain beat of one vector against the capture of the next: with equal input and neuron counts, vectors are streamed back to back. The bench then requires each vector's first beat exactly eight cycles after the previous one, with sums matching its reference model, so a capture that clobbers a pending beat shows up as a wrong sum or a missing index.

// File: rtl/tern_fc_pkg.sv
package tern_fc_pkg;

  typedef logic [1:0] tern_t;

  localparam tern_t TERN_ZERO = 2'b00;
  localparam tern_t TERN_POS  = 2'b01;
  localparam tern_t TERN_NEG  = 2'b11;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2
  } tern_op_e;

  // nonzero only for the two legal signed codes; 2'b10 behaves as zero
  function automatic logic tern_nz(tern_t v);
    return (v == TERN_POS) || (v == TERN_NEG);
  endfunction

  // weight x activation reduced to an accumulator action
  function automatic tern_op_e tern_op(tern_t w, tern_t a);
    if (!tern_nz(w) || !tern_nz(a)) return OP_HOLD;
    return (w[1] ^ a[1]) ? OP_DEC : OP_INC;
  endfunction

endpackage

// File: rtl/tern_wmem.sv
module tern_wmem
  import tern_fc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  tern_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output tern_t         rdata
);

  tern_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tern_frame_ctrl.sv
module tern_frame_ctrl #(
  parameter int N_IN = 8,
  localparam int IW = $clog2(N_IN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          accept,
  output logic [IW-1:0] rd_addr,
  output logic          open_o,
  output logic          s1_valid,
  output logic          s1_sof,
  output logic          s1_last
);

  localparam logic [IW-1:0] LAST_POS = IW'(N_IN - 1);

  logic          open_q;
  logic [IW-1:0] cnt;
  logic          is_last;

  always_comb begin
    accept  = in_valid && (in_sof || open_q);
    rd_addr = in_sof ? '0 : cnt;
    is_last = !in_sof && (cnt == LAST_POS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      cnt      <= '0;
      s1_valid <= 1'b0;
      s1_sof   <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      s1_valid <= accept;
      s1_sof   <= accept && in_sof;
      s1_last  <= accept && is_last;
      if (accept) begin
        if (in_sof) begin
          open_q <= 1'b1;
          cnt    <= IW'(1);
        end else if (is_last) begin
          open_q <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt    <= cnt + 1'b1;
        end
      end
    end
  end

  assign open_o = open_q;

  // R6
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    s1_last |-> !open_q);

  // R5
  sof_open_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (open_q && s1_sof && cnt == IW'(1)));

  // R7
  stray_input_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sof && !open_q) |=> !s1_valid);

endmodule

// File: rtl/tern_neuron.sv
module tern_neuron
  import tern_fc_pkg::*;
#(
  parameter int AW  = 5,
  parameter int LIM = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step_v,
  input  logic                 step_sof,
  input  tern_t                w,
  input  tern_t                a,
  output logic signed [AW-1:0] sum_next
);

  localparam logic signed [AW-1:0] ONE   = AW'(1);
  localparam logic signed [AW-1:0] LIM_S = AW'(LIM);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] base;
  tern_op_e             op;

  always_comb begin
    base = step_sof ? '0 : acc;
    op   = tern_op(w, a);
    case (op)
      OP_INC:  sum_next = base + ONE;
      OP_DEC:  sum_next = base - ONE;
      default: sum_next = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (step_v) acc <= sum_next;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc <= LIM_S) && (acc >= -LIM_S));

  // R3
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (step_v && !step_sof && (!tern_nz(w) || !tern_nz(a))) |=> (acc == $past(acc)));

  // R5
  sof_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (step_v && step_sof) |=> ((acc >= -ONE) && (acc <= ONE)));

endmodule

// File: rtl/tern_drain.sv
module tern_drain #(
  parameter int N_NEUR = 8,
  parameter int AW     = 5,
  localparam int XW = $clog2(N_NEUR),
  localparam int CW = $clog2(N_NEUR + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap,
  input  logic signed [AW-1:0] sums_i [N_NEUR],
  output logic                 busy,
  output logic                 out_valid,
  output logic [XW-1:0]        out_idx,
  output logic signed [AW-1:0] out_sum,
  output logic                 out_last
);

  logic signed [AW-1:0] sh [N_NEUR];
  logic [CW-1:0]        dcnt;

  assign busy = (dcnt != '0);

  // data path: no reset, plain shift register
  always_ff @(posedge clk) begin
    if (cap) begin
      sh <= sums_i;
    end else if (busy) begin
      for (int k = 0; k < N_NEUR - 1; k++) sh[k] <= sh[k+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt      <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_sum   <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= busy;
      out_last  <= busy && (dcnt == CW'(1));
      if (busy) begin
        out_sum <= sh[0];
        out_idx <= XW'(N_NEUR - int'(dcnt));
      end
      if (cap)       dcnt <= CW'(N_NEUR);
      else if (busy) dcnt <= dcnt - 1'b1;
    end
  end

  // R6
  idx_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  // R6
  last_idx_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && out_idx == XW'(N_NEUR - 1)));

  // R10
  cap_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    cap |-> (dcnt <= CW'(1)));

endmodule

// File: rtl/tern_fc_layer.sv
module tern_fc_layer
  import tern_fc_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_NEUR = 8,
  localparam int IW = $clog2(N_IN),
  localparam int NW = $clog2(N_NEUR),
  localparam int AW = $clog2(N_IN + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic [1:0]           in_act,
  input  logic                 wr_en,
  input  logic [NW-1:0]        wr_neuron,
  input  logic [IW-1:0]        wr_index,
  input  logic [1:0]           wr_data,
  output logic                 idle,
  output logic                 out_valid,
  output logic [NW-1:0]        out_idx,
  output logic signed [AW-1:0] out_sum,
  output logic                 out_last
);

  logic                 accept;
  logic [IW-1:0]        rd_addr;
  logic                 frame_open;
  logic                 s1_valid, s1_sof, s1_last;
  logic                 drain_busy;
  logic                 wr_ok;
  tern_t                act_q;
  logic [N_NEUR-1:0]    we_vec;
  logic signed [AW-1:0] nsum [N_NEUR];

  tern_frame_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .accept   (accept),
    .rd_addr  (rd_addr),
    .open_o   (frame_open),
    .s1_valid (s1_valid),
    .s1_sof   (s1_sof),
    .s1_last  (s1_last)
  );

  // activation aligned with the one-cycle weight read
  always_ff @(posedge clk) begin
    if (rst)         act_q <= TERN_ZERO;
    else if (accept) act_q <= in_act;
  end

  assign idle  = !frame_open && !s1_valid && !drain_busy;
  assign wr_ok = wr_en && idle && !(in_valid && in_sof);

  for (genvar g = 0; g < N_NEUR; g++) begin : g_neuron
    tern_t w_rd;

    assign we_vec[g] = wr_ok && (wr_neuron == NW'(g));

    tern_wmem #(.DEPTH(N_IN)) u_mem (
      .clk   (clk),
      .we    (we_vec[g]),
      .waddr (wr_index),
      .wdata (wr_data),
      .re    (accept),
      .raddr (rd_addr),
      .rdata (w_rd)
    );

    tern_neuron #(.AW(AW), .LIM(N_IN)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .step_v   (s1_valid),
      .step_sof (s1_sof),
      .w        (w_rd),
      .a        (act_q),
      .sum_next (nsum[g])
    );
  end

  tern_drain #(.N_NEUR(N_NEUR), .AW(AW)) u_drain (
    .clk       (clk),
    .rst       (rst),
    .cap       (s1_valid && s1_last),
    .sums_i    (nsum),
    .busy      (drain_busy),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_sum   (out_sum),
    .out_last  (out_last)
  );

  // R9
  wr_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle || (in_valid && in_sof)) |-> (we_vec == '0));

  // R8
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_vec));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && idle));

endmodule

// File: tb/tb_tern_fc_layer.sv
`timescale 1ns/1ps
module tb_tern_fc_layer;

  localparam int N_IN   = 8;
  localparam int N_NEUR = 8;
  localparam int IW = $clog2(N_IN);
  localparam int NW = $clog2(N_NEUR);
  localparam int AW = $clog2(N_IN + 1) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [1:0] in_act = 2'b00;
  logic wr_en = 1'b0;
  logic [NW-1:0] wr_neuron = '0;
  logic [IW-1:0] wr_index = '0;
  logic [1:0] wr_data = 2'b00;
  logic idle, out_valid, out_last;
  logic [NW-1:0] out_idx;
  logic signed [AW-1:0] out_sum;

  tern_fc_layer #(.N_IN(N_IN), .N_NEUR(N_NEUR)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_act(in_act),
    .wr_en(wr_en), .wr_neuron(wr_neuron), .wr_index(wr_index), .wr_data(wr_data),
    .idle(idle), .out_valid(out_valid), .out_idx(out_idx), .out_sum(out_sum),
    .out_last(out_last)
  );

  always #2 clk = ~clk;

  logic [1:0] W [N_NEUR][N_IN];
  logic [1:0] A [N_IN];
  int exp_q[$];
  int eidx_q[$];
  string tag_q[$];
  int lat_q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int tv(logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int dot(int k);
    int s = 0;
    for (int i = 0; i < N_IN; i++) s += tv(W[k][i]) * tv(A[i]);
    return s;
  endfunction

  function automatic logic [1:0] rcode();
    case ($urandom % 4)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [1:0] flip(logic [1:0] c);
    return (c == 2'b01) ? 2'b11 : 2'b01;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R6 unexpected out_valid beat", int'(out_idx), -1);
      end else begin
        int e, ei;
        string t;
        e = exp_q.pop_front();
        ei = eidx_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(out_sum) == e, t, int'(out_sum), e);
        chk(int'(out_idx) == ei && out_last == (ei == N_NEUR - 1),
            "R6 index/last", int'(out_idx) * 2 + int'(out_last), ei * 2 + int'(ei == N_NEUR - 1));
        if (ei == 0) begin
          int lt;
          lt = lat_q.pop_front();
          chk(cyc == lt, "R6 R10 first beat cycle", cyc, lt);
        end
      end
    end
  end

  task automatic send_frame(bit gaps);
    for (int i = 0; i < N_IN; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 0; in_sof = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_sof = (i == 0);
      in_act = A[i];
      if (i == N_IN - 1) begin
        for (int k = 0; k < N_NEUR; k++) begin
          exp_q.push_back(dot(k));
          eidx_q.push_back(k);
          tag_q.push_back(cur_tag);
        end
        lat_q.push_back(cyc + 3);
      end
      @(negedge clk);
    end
    in_valid = 0;
    in_sof = 0;
  endtask

  task automatic wr(int n, int i, logic [1:0] d);
    wr_en = 1;
    wr_neuron = NW'(n);
    wr_index = IW'(i);
    wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    while (!idle || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rand_acts();
    for (int i = 0; i < N_IN; i++) A[i] = rcode();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
      report();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(out_valid == 0, "R11 out_valid after reset", int'(out_valid), 0);
    chk(idle == 1, "R11 idle after reset", int'(idle), 1);

    // directed weights: rows of +1, -1, 0 and one mixed row with 2'b10 (R1)
    for (int k = 0; k < N_NEUR; k++)
      for (int i = 0; i < N_IN; i++) begin
        case (k % 3)
          0: W[k][i] = 2'b01;
          1: W[k][i] = 2'b11;
          default: W[k][i] = 2'b00;
        endcase
        if (k == N_NEUR - 1) W[k][i] = (i % 2 == 0) ? 2'b10 : 2'b01;
        wr(k, i, W[k][i]);
      end

    cur_tag = "R2 all +1 extremes";
    for (int i = 0; i < N_IN; i++) A[i] = 2'b01;
    send_frame(0);
    wait_idle();
    cur_tag = "R2 all -1 extremes";
    for (int i = 0; i < N_IN; i++) A[i] = 2'b11;
    send_frame(0);
    wait_idle();
    cur_tag = "R3 zero vector";
    for (int i = 0; i < N_IN; i++) A[i] = 2'b00;
    send_frame(0);
    wait_idle();
    cur_tag = "R1 code 10 as zero";
    for (int i = 0; i < N_IN; i++) A[i] = 2'b10;
    send_frame(0);
    wait_idle();

    // random weights
    for (int k = 0; k < N_NEUR; k++)
      for (int i = 0; i < N_IN; i++) begin
        W[k][i] = rcode();
        wr(k, i, W[k][i]);
      end

    cur_tag = "R4 random with pauses";
    for (int f = 0; f < 20; f++) begin
      rand_acts();
      send_frame(1);
    end
    wait_idle();

    cur_tag = "R10 back-to-back";
    for (int f = 0; f < 10; f++) begin
      rand_acts();
      send_frame(0);
    end
    wait_idle();

    // R7 stray inputs with no open vector
    in_valid = 1; in_sof = 0; in_act = 2'b01;
    repeat (5) @(negedge clk);
    in_valid = 0;
    repeat (4) @(negedge clk);
    chk(idle == 1, "R7 idle after stray inputs", int'(idle), 1);
    chk(exp_q.size() == 0, "R7 no output after stray inputs", exp_q.size(), 0);

    // R5 restart mid-vector
    for (int i = 0; i < 3; i++) begin
      in_valid = 1; in_sof = (i == 0); in_act = 2'b01;
      @(negedge clk);
    end
    cur_tag = "R5 restart mid-vector";
    rand_acts();
    send_frame(0);
    wait_idle();

    // R9 write during an open vector is dropped
    cur_tag = "R9 write during vector";
    rand_acts();
    fork
      send_frame(0);
      begin
        repeat (3) @(negedge clk);
        wr(0, 0, flip(W[0][0]));
      end
    join
    wait_idle();
    rand_acts();
    send_frame(0);
    wait_idle();

    // R9 write in the same cycle as the accepted sof is dropped
    cur_tag = "R9 write on sof cycle";
    rand_acts();
    fork
      send_frame(0);
      wr(1, 2, flip(W[1][2]));
    join
    wait_idle();

    // R9 write while draining is dropped; idle low then
    cur_tag = "R9 write during drain";
    rand_acts();
    fork
      send_frame(0);
      begin
        repeat (N_IN + 3) @(negedge clk);
        chk(idle == 0, "R9 idle low while draining", int'(idle), 0);
        wr(2, 5, flip(W[2][5]));
      end
    join
    wait_idle();
    for (int i = 0; i < N_IN; i++) A[i] = 2'b01;
    send_frame(0);
    wait_idle();

    // R8 accepted write changes later vectors
    cur_tag = "R8 accepted write";
    W[3][4] = flip(W[3][4]);
    wr(3, 4, W[3][4]);
    W[6][0] = 2'b11;
    wr(6, 0, W[6][0]);
    for (int i = 0; i < N_IN; i++) A[i] = 2'b01;
    send_frame(0);
    wait_idle();
    rand_acts();
    send_frame(0);
    wait_idle();

    chk(idle == 1, "R9 idle once drained", int'(idle), 1);
    report();
  end

endmodule